// File: doc/BRIEF.md
# Event Prescaler with Pulse Capture

This block slows a fast event line down to a rate that slower measurement logic can follow, and it keeps a running tally of the input pulses. The event line is brought into the block clock domain by a synchronizer. Each rising edge found on the synchronized copy advances two things: a toggle divider, which drives a square-wave output event, and a 16-bit pulse counter.

A single select bit picks one of two division ratios. Software controls the block through an active-low run bit: while that bit is low, the block is held in a known state. It reads the pulse tally by pulsing a capture request, which copies the live counter into a readable output register. The divided output is meant to serve as both the start event and the stop event of an interval counter, so that slow logic can time a fast signal.

Top module: `evtPrescaler`

## Requirements
- R1: After the hardware reset `rstN`, `divOut` is 0 and `capValue` is 0.
- R2: While `runN` is 0, `divOut` is 0 and the pulse counter is held at 2. Input edges seen during this time have no effect on either.
- R3: With `ratioSel` = 0, `divOut` toggles on every 8th counted rising edge, starting from 0. It is therefore 1 after 8 edges and 0 again after 16.
- R4: With `ratioSel` = 1, `divOut` toggles on every 32nd counted rising edge. It is therefore 1 after 32 edges and 0 again after 64.
- R5: A one-cycle pulse on `capReq` copies the live pulse counter into `capValue` at the next clock edge. Without a pulse, `capValue` keeps its value.
- R6: If fewer than 3 rising edges have been counted since `runN` went high, a capture returns 2.
- R7: If N ≥ 3 rising edges have been counted since `runN` went high, a capture returns N−1.
- R8: The pulse counter stops at 0xFFFF and does not wrap.
- R9: If the input is already high when `runN` rises, that level is not counted as an edge.
- R10: Dropping `runN` leaves `capValue` unchanged. A capture taken while `runN` is 0 returns 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| runN | input | 1 | Soft run bit, active low; 0 holds the prescaler in reset |
| ratioSel | input | 1 | Division select: 0 divides by 16, 1 divides by 64 |
| evtIn | input | 1 | Asynchronous input event |
| capReq | input | 1 | Capture request, one cycle wide |
| divOut | output | 1 | Divided output event (square wave) |
| capValue | output | 16 | Last captured pulse count |

## Verification
The assertions assume that `evtIn` holds each level for at least one full clock period, so the synchronizer never misses an edge. They also assume that `capReq` is a clean single-cycle strobe sampled on the clock. The stimulus drives every input on the falling clock edge. The fastest pattern it uses toggles `evtIn` every clock, which is exactly half the clock rate. The capture window and the divider checks are sampled four cycles after the last edge, which covers the synchronizer and edge-detect latency.

// File: rtl/evtPrescalerPkg.sv
package evtPrescalerPkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic hold;     // soft reset active
    logic rise;     // one counted rising edge
    logic capture;  // latch pulse counter
  } presStrobe_t;
endpackage

// File: rtl/evtSync.sv
module evtSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/evtPrescalerCtrl.sv
module evtPrescalerCtrl
  import evtPrescalerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runN,
  input  logic        evtIn,
  input  logic        capReq,
  output presStrobe_t strobes
);
  logic evtSynced;
  logic evtPrev;

  evtSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (evtIn),
    .dout (evtSynced)
  );

  // Keeps tracking the level during hold, so a level already high at release
  // is not taken as an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= evtSynced;
  end

  always_comb begin
    strobes.hold    = !runN;
    strobes.rise    = runN && evtSynced && !evtPrev;
    strobes.capture = capReq;
  end
endmodule

// File: rtl/evtPrescalerDp.sv
module evtPrescalerDp
  import evtPrescalerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CNT_INIT    = 2,
  parameter int WARM_EDGES  = 3,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 64,
  parameter bit SATURATE    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ratioSel,
  input  presStrobe_t       strobes,
  output logic              divOut,
  output logic [CNT_W-1:0]  capValue
);
  localparam int HALF_LO = DIV_LO / 2;
  localparam int HALF_HI = DIV_HI / 2;
  localparam int TGL_W   = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;
  localparam int WARM_W  = $clog2(WARM_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(CNT_INIT);

  // ---------------- toggle divider ----------------
  logic [TGL_W-1:0] tglCnt;
  logic [TGL_W-1:0] tglLimit;

  always_comb tglLimit = ratioSel ? TGL_W'(HALF_HI - 1) : TGL_W'(HALF_LO - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tglCnt <= '0;
      divOut <= 1'b0;
    end else if (strobes.hold) begin
      tglCnt <= '0;
      divOut <= 1'b0;
    end else if (strobes.rise) begin
      if (tglCnt >= tglLimit) begin
        tglCnt <= '0;
        divOut <= !divOut;
      end else begin
        tglCnt <= tglCnt + 1'b1;
      end
    end
  end

  // ---------------- pulse counter ----------------
  logic [WARM_W-1:0] warmCnt;
  logic [CNT_W-1:0]  pulseCnt;
  logic              atTop;

  generate
    if (SATURATE) begin : g_sat
      assign atTop = &pulseCnt;
    end else begin : g_wrap
      assign atTop = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= '0;
      pulseCnt <= CNT_RST;
    end else if (strobes.hold) begin
      warmCnt  <= '0;
      pulseCnt <= CNT_RST;
    end else if (strobes.rise) begin
      if (warmCnt < WARM_W'(WARM_EDGES)) begin
        warmCnt <= warmCnt + 1'b1;
      end else if (!atTop) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  // ---------------- capture register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capValue <= '0;
    else if (strobes.capture) capValue <= pulseCnt;
  end
endmodule

// File: rtl/evtPrescaler.sv
module evtPrescaler
  import evtPrescalerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CNT_INIT    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runN,
  input  logic             ratioSel,
  input  logic             evtIn,
  input  logic             capReq,
  output logic             divOut,
  output logic [CNT_W-1:0] capValue
);
  presStrobe_t strobes;

  evtPrescalerCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runN    (runN),
    .evtIn   (evtIn),
    .capReq  (capReq),
    .strobes (strobes)
  );

  evtPrescalerDp #(
    .CNT_W      (CNT_W),
    .CNT_INIT   (CNT_INIT),
    .WARM_EDGES (CNT_INIT + 1),
    .DIV_LO     (DIV_LO),
    .DIV_HI     (DIV_HI),
    .SATURATE   (1'b1)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .strobes  (strobes),
    .divOut   (divOut),
    .capValue (capValue)
  );
endmodule

// File: rtl/evtPrescalerChk.sv
module evtPrescalerChk #(
  parameter int CNT_W    = 16,
  parameter int CNT_INIT = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             runN,
  input logic             capReq,
  input logic             divOut,
  input logic [CNT_W-1:0] capValue
);
  // R2
  hold_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runN |=> !divOut);

  // R5
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capReq |=> $stable(capValue));

  // R6
  cap_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    capReq |=> (capValue >= CNT_W'(CNT_INIT)));

  // R3
  div_rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divOut) |-> $past(runN));
endmodule

bind evtPrescaler evtPrescalerChk #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runN     (runN),
  .capReq   (capReq),
  .divOut   (divOut),
  .capValue (capValue)
);

// File: tb/evtPrescaler_tb.sv
module evtPrescaler_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runN = 1'b0;
  logic        ratioSel = 1'b0;
  logic        evtIn = 1'b0;
  logic        capReq = 1'b0;
  logic        divOut;
  logic [15:0] capValue;

  int nCmp = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtPrescaler u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .runN     (runN),
    .ratioSel (ratioSel),
    .evtIn    (evtIn),
    .capReq   (capReq),
    .divOut   (divOut),
    .capValue (capValue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      evtIn = 1'b1; @(negedge clk);
      evtIn = 1'b0; @(negedge clk);
    end
    settle();
  endtask

  task automatic capture();
    capReq = 1'b1; @(negedge clk);
    capReq = 1'b0;
  endtask

  task automatic restart(input logic ratio);
    runN = 1'b0; ratioSel = ratio; evtIn = 1'b0;
    settle();
    runN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 divOut", divOut, 0);
    check("R1 capValue", capValue, 0);
  endtask

  task automatic testHold();
    runN = 1'b0; @(negedge clk);
    pulses(20);
    check("R2 divOut held", divOut, 0);
    capture();
    check("R2 counter held at 2", capValue, 2);
  endtask

  task automatic testRatioLo();
    restart(1'b0);
    pulses(7);  check("R3 after 7", divOut, 0);
    pulses(1);  check("R3 after 8", divOut, 1);
    pulses(7);  check("R3 after 15", divOut, 1);
    pulses(1);  check("R3 after 16", divOut, 0);
  endtask

  task automatic testRatioHi();
    restart(1'b1);
    pulses(31); check("R4 after 31", divOut, 0);
    pulses(1);  check("R4 after 32", divOut, 1);
    pulses(32); check("R4 after 64", divOut, 0);
  endtask

  task automatic testCountSmall();
    restart(1'b0);
    capture(); check("R6 zero edges", capValue, 2);
    pulses(2); capture(); check("R6 two edges", capValue, 2);
    pulses(1); capture(); check("R7 three edges", capValue, 2);
    pulses(1); capture(); check("R7 four edges", capValue, 3);
    pulses(6); capture(); check("R7 ten edges", capValue, 9);
    pulses(3);
    check("R5 no capture keeps value", capValue, 9);
  endtask

  task automatic testHighAtRelease();
    runN = 1'b0; evtIn = 1'b1;
    settle();
    runN = 1'b1;
    settle();
    evtIn = 1'b0; @(negedge clk);
    pulses(5);
    capture();
    check("R9 level at release ignored", capValue, 4);
  endtask

  task automatic testSoftResetKeepsCap();
    restart(1'b0);
    pulses(12); capture();
    check("R5 capture twelve", capValue, 11);
    runN = 1'b0; settle();
    check("R10 capValue kept", capValue, 11);
    capture();
    check("R10 capture in hold", capValue, 2);
  endtask

  task automatic testSaturate();
    restart(1'b0);
    pulses(65540);
    capture();
    check("R8 saturates", capValue, 16'hFFFF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testRatioLo();
    testRatioHi();
    testCountSmall();
    testHighAtRelease();
    testSoftResetKeepsCap();
    testSaturate();
    finish();
  end
endmodule